// File: doc/BRIEF.md
# Run-Length Pixel Token Decoder

This block turns a stream of compact 16-bit pixel tokens into a 9-bit RGB value, with one value for each pixel clock enable. Every token pairs a colour with a command. A run command holds that colour on the output for one of eight fixed pixel counts. A control command drives its colour and then stops fetching until the sync generator signals a frame start or a line start. The block does not count pixels across a line. The token stream is built so that its runs add up to each visible line, and each line is closed with a wait-for-line token.

Tokens arrive on a valid/ready stream. The decoder takes a new token only at the pixel boundary where the current run ends, so the stream advances by at most one token per run. If the stream is empty at that boundary, the output drops to black and a sticky underflow flag records the event.

Top module: `pixel_run_decoder`

## Requirements
- R1: A token's bits 8:0 are the colour and bits 15:9 are the command code. The colour of an accepted token appears on `rgb_out` from the clock after the edge that accepts it.
- R2: Command codes 0 to 7 hold the colour for 1, 2, 4, 7, 8, 14, 16 and 32 pixel-enable periods, in that order. The next token is accepted exactly that many pixel-enable edges later.
- R3: Command codes 10 to 127 behave as a run of one pixel.
- R4: `tok_ready` is high only in a cycle with `pix_en`, `tok_valid` and the last pixel of the current run all present, so one token is consumed per run.
- R5: `rgb_out` changes only at clock edges where `pix_en` was high.
- R6: Code 9 drives its colour and then accepts no token until `line_mark` is seen. The first `pix_en` cycle after the `line_mark` cycle accepts the next token.
- R7: Code 8 drives its colour and then waits for `frame_mark`. A `line_mark` before or in the same cycle as `frame_mark` does not release it. After the frame marker it waits for a later `line_mark`, as in R6.
- R8: `frame_mark` and `line_mark` have no effect while a run is in progress.
- R9: If no token is valid when a run ends, `rgb_out` is forced to 0 and `underflow` is set, and a fetch is retried on every later `pix_en`. `underflow` stays set until reset.
- R10: Reset drives `rgb_out` to 0 and clears `underflow`. The decoder then waits for a frame marker as in R7, with `tok_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel clock enable; one pixel per high cycle |
| tok_valid | input | 1 | Token stream valid |
| tok_data | input | 16 | Token: command in 15:9, colour in 8:0 |
| tok_ready | output | 1 | Token accepted this cycle |
| frame_mark | input | 1 | Frame-start pulse from the sync generator |
| line_mark | input | 1 | Line-start pulse from the sync generator |
| rgb_out | output | 9 | Pixel colour |
| underflow | output | 1 | Sticky: a run ended with no token available |

## Verification
A wrong run counter or code lookup appears at the next fetch. `tok_ready` then rises one or more pixel edges too early or too late, so the bench measures the gap between successive accepts in pixel edges for every code. A wrong wait state shows up in two ways: `tok_ready` rises before the proper marker, or the next colour misses the first pixel enable after `line_mark`. Both are visible within one pixel of the marker. A lost underflow bit is visible at the very next fetch after the flag should still have been held.

// File: rtl/prt_pkg.sv
`timescale 1ns/1ps
package prt_pkg;

  localparam int NUM_RUN_CODES = 8;
  localparam int MAX_RUN       = 32;
  localparam int CODE_WFRAME   = 8;
  localparam int CODE_WLINE    = 9;

  typedef enum logic [1:0] {
    TK_RUN    = 2'd0,
    TK_WFRAME = 2'd1,
    TK_WLINE  = 2'd2
  } tok_kind_e;

  typedef enum logic [1:0] {
    SQ_RUN    = 2'd0,
    SQ_WFRAME = 2'd1,
    SQ_WLINE  = 2'd2
  } seq_state_e;

  // Pixel count held by each run code; the order is the code value.
  function automatic int unsigned run_pixels(input int unsigned code);
    case (code)
      0:       return 1;
      1:       return 2;
      2:       return 4;
      3:       return 7;
      4:       return 8;
      5:       return 14;
      6:       return 16;
      7:       return 32;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/prt_cmd_decode.sv
`timescale 1ns/1ps
module prt_cmd_decode
  import prt_pkg::*;
#(
  parameter int CMD_W = 7,
  parameter int CNT_W = 6
) (
  input  logic [CMD_W-1:0] cmd,
  output tok_kind_e        kind,
  output logic [CNT_W-1:0] len
);

  localparam int IDX_W = $clog2(NUM_RUN_CODES);

  logic [CNT_W-1:0] lut [NUM_RUN_CODES];

  for (genvar g = 0; g < NUM_RUN_CODES; g++) begin : g_lut
    assign lut[g] = CNT_W'(run_pixels(g));
  end

  always_comb begin
    kind = TK_RUN;
    len  = CNT_W'(1);
    if (cmd < CMD_W'(NUM_RUN_CODES)) begin
      len = lut[cmd[IDX_W-1:0]];
    end else if (cmd == CMD_W'(CODE_WFRAME)) begin
      kind = TK_WFRAME;
    end else if (cmd == CMD_W'(CODE_WLINE)) begin
      kind = TK_WLINE;
    end
  end

endmodule

// File: rtl/prt_run_counter.sv
`timescale 1ns/1ps
module prt_run_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(1);
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNT_W'(1));

  // R2
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);

  // R4
  dec_not_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !last);

endmodule

// File: rtl/prt_sequencer.sv
`timescale 1ns/1ps
module prt_sequencer
  import prt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pix_en,
  input  logic      last,
  input  logic      tok_valid,
  input  tok_kind_e kind,
  input  logic      frame_mark,
  input  logic      line_mark,
  output logic      accept,
  output logic      starve,
  output logic      dec,
  output logic      load,
  output logic      load_run
);

  seq_state_e st_q, st_d;
  logic       fetch_slot;
  logic       release_line;

  always_comb begin
    fetch_slot   = pix_en && (st_q == SQ_RUN) && last;
    accept       = fetch_slot && tok_valid;
    starve       = fetch_slot && !tok_valid;
    dec          = pix_en && (st_q == SQ_RUN) && !last;
    release_line = (st_q == SQ_WLINE) && line_mark;
    load         = accept || release_line;
    load_run     = accept && (kind == TK_RUN);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_RUN: begin
        if (accept) begin
          if (kind == TK_WFRAME)     st_d = SQ_WFRAME;
          else if (kind == TK_WLINE) st_d = SQ_WLINE;
        end
      end
      SQ_WFRAME: if (frame_mark) st_d = SQ_WLINE;
      SQ_WLINE:  if (line_mark)  st_d = SQ_RUN;
      default:   st_d = SQ_WFRAME;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_WFRAME;
    else        st_q <= st_d;
  end

  // R7
  wframe_no_direct_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_WFRAME) |=> (st_q != SQ_RUN));

  // R6
  no_fetch_while_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SQ_RUN) |-> !(accept || starve || dec));

endmodule

// File: rtl/prt_pixel_out.sv
`timescale 1ns/1ps
module prt_pixel_out #(
  parameter int COLOR_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_en,
  input  logic               accept,
  input  logic               starve,
  input  logic [COLOR_W-1:0] colour,
  output logic [COLOR_W-1:0] rgb,
  output logic               underflow
);

  logic [COLOR_W-1:0] rgb_q, rgb_d;
  logic               und_q, und_d;

  always_comb begin
    rgb_d = rgb_q;
    if (accept)      rgb_d = colour;
    else if (starve) rgb_d = '0;
    und_d = und_q || starve;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_q <= '0;
      und_q <= 1'b0;
    end else begin
      rgb_q <= rgb_d;
      und_q <= und_d;
    end
  end

  assign rgb       = rgb_q;
  assign underflow = und_q;

  // R5
  rgb_pixel_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(rgb_q));

  // R9
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    und_q |=> und_q);

endmodule

// File: rtl/pixel_run_decoder.sv
`timescale 1ns/1ps
module pixel_run_decoder
  import prt_pkg::*;
#(
  parameter int COLOR_W = 9,
  parameter int CMD_W   = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pix_en,
  input  logic                       tok_valid,
  input  logic [COLOR_W+CMD_W-1:0]   tok_data,
  output logic                       tok_ready,
  input  logic                       frame_mark,
  input  logic                       line_mark,
  output logic [COLOR_W-1:0]         rgb_out,
  output logic                       underflow
);

  localparam int TOK_W = COLOR_W + CMD_W;
  localparam int CNT_W = $clog2(MAX_RUN + 1);

  logic [COLOR_W-1:0] colour;
  logic [CMD_W-1:0]   cmd;
  tok_kind_e          kind;
  logic [CNT_W-1:0]   len;
  logic [CNT_W-1:0]   load_val;
  logic               last, accept, starve, dec, load, load_run;

  assign colour = tok_data[COLOR_W-1:0];
  assign cmd    = tok_data[TOK_W-1:COLOR_W];

  prt_cmd_decode #(.CMD_W(CMD_W), .CNT_W(CNT_W)) u_dec (
    .cmd  (cmd),
    .kind (kind),
    .len  (len)
  );

  prt_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_en     (pix_en),
    .last       (last),
    .tok_valid  (tok_valid),
    .kind       (kind),
    .frame_mark (frame_mark),
    .line_mark  (line_mark),
    .accept     (accept),
    .starve     (starve),
    .dec        (dec),
    .load       (load),
    .load_run   (load_run)
  );

  assign load_val = load_run ? len : CNT_W'(1);

  prt_run_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .dec      (dec),
    .last     (last)
  );

  prt_pixel_out #(.COLOR_W(COLOR_W)) u_pix (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_en    (pix_en),
    .accept    (accept),
    .starve    (starve),
    .colour    (colour),
    .rgb       (rgb_out),
    .underflow (underflow)
  );

  assign tok_ready = accept;

  // R4
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_ready |-> (tok_valid && pix_en));

  // R1
  colour_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_ready |=> (rgb_out == $past(tok_data[COLOR_W-1:0])));

  // R9
  starve_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> (rgb_out == '0));

endmodule

// File: tb/tb_pixel_run_decoder.sv
`timescale 1ns/1ps
module tb_pixel_run_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_en;
  logic        tok_valid;
  logic [15:0] tok_data;
  logic        tok_ready;
  logic        frame_mark;
  logic        line_mark;
  logic [8:0]  rgb_out;
  logic        underflow;

  int n_chk  = 0;
  int n_fail = 0;
  int div    = 1;
  int ph     = 0;
  int pix_edges = 0;

  pixel_run_decoder dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .tok_valid(tok_valid), .tok_data(tok_data), .tok_ready(tok_ready),
    .frame_mark(frame_mark), .line_mark(line_mark),
    .rgb_out(rgb_out), .underflow(underflow)
  );

  always #10 clk = ~clk;

  initial begin
    pix_en = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      ph++;
      pix_en = ((ph % div) == 0);
    end
  end

  always @(posedge clk) if (pix_en) pix_edges <= pix_edges + 1;

  // {command, colour, expected run length}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {7'd0,   9'h101, 7'd1},
    {7'd1,   9'h0F2, 7'd2},
    {7'd2,   9'h1E3, 7'd4},
    {7'd3,   9'h0D4, 7'd7},
    {7'd4,   9'h1C5, 7'd8},
    {7'd5,   9'h0B6, 7'd14},
    {7'd6,   9'h1A7, 7'd16},
    {7'd7,   9'h098, 7'd32},
    {7'd10,  9'h189, 7'd1},
    {7'd127, 9'h07A, 7'd1},
    {7'd3,   9'h16B, 7'd7},
    {7'd0,   9'h05C, 7'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // Present a token, wait for acceptance, return the pixel-edge index and check colour.
  task automatic push(input logic [15:0] t, input string req, output int idx);
    int waited;
    @(negedge clk);
    tok_valid = 1'b1;
    tok_data  = t;
    #1;
    waited = 0;
    while (!tok_ready && waited < 500) begin
      @(negedge clk);
      #1;
      waited++;
    end
    if (!tok_ready) check({req, " token never accepted"}, 0, 1);
    idx = pix_edges;
    @(posedge clk);
    #1;
    check({req, " R1 colour"}, 32'(rgb_out), 32'(t[8:0]));
  endtask

  task automatic pulse(input logic f, input logic l);
    @(negedge clk);
    frame_mark = f;
    line_mark  = l;
    @(negedge clk);
    frame_mark = 1'b0;
    line_mark  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int idx [NV+1];
    int ia, ib;
    rst_n = 1'b0; tok_valid = 1'b1; tok_data = {7'd9, 9'h0A5};
    frame_mark = 1'b0; line_mark = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state, no token taken although valid and pix_en are high
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      check("R10 ready", 32'(tok_ready), 0);
    end
    check("R10 rgb", 32'(rgb_out), 0);
    check("R10 underflow", 32'(underflow), 0);

    // R7: line marker alone, or together with frame marker, does not release
    pulse(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    #1 check("R7 line before frame", 32'(tok_ready), 0);
    pulse(1'b1, 1'b1);
    repeat (4) @(negedge clk);
    #1 check("R7 coincident markers", 32'(tok_ready), 0);

    // R6: release on the first pixel enable after the line marker
    @(negedge clk);
    line_mark = 1'b1;
    #1 check("R6 no fetch in marker cycle", 32'(tok_ready), 0);
    @(negedge clk);
    line_mark = 1'b0;
    #1 check("R6 fetch on first pixel", 32'(tok_ready), 1);
    @(posedge clk);
    #1 check("R6 control colour", 32'(rgb_out), 32'h0A5);

    // R6: waiting for line, the next token is held off
    @(negedge clk);
    tok_data = {VEC[0][22:16], VEC[0][15:7]};
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); #1;
      check("R6 wait holds ready", 32'(tok_ready), 0);
    end
    check("R6 wait holds colour", 32'(rgb_out), 32'h0A5);

    // R2/R3: table walk with pixel enable every other clock
    div = 2;
    pulse(1'b0, 1'b1);
    for (int i = 0; i < NV; i++) begin
      push({VEC[i][22:16], VEC[i][15:7]}, "R2 table", idx[i]);
    end
    push({7'd9, 9'h000}, "R6 terminator", idx[NV]);
    for (int i = 0; i < NV; i++) begin
      check((VEC[i][22:16] > 7) ? "R3 run length" : "R2 run length",
            32'(idx[i+1] - idx[i]), 32'(VEC[i][6:0]));
    end

    // R8: markers during a run have no effect; R5 colour steady inside run
    @(negedge clk);
    tok_data = {7'd7, 9'h1F0};
    pulse(1'b0, 1'b1);
    push({7'd7, 9'h1F0}, "R8 long run", ia);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      check("R5 colour held", 32'(rgb_out), 32'h1F0);
    end
    pulse(1'b1, 1'b1);
    push({7'd9, 9'h0C3}, "R8 terminator", ib);
    check("R8 run length unchanged", 32'(ib - ia), 32);

    // R9: underflow forces black and sticks
    @(negedge clk);
    tok_valid = 1'b0;
    #1 check("R9 flag clear before", 32'(underflow), 0);
    pulse(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    #1 check("R9 rgb forced", 32'(rgb_out), 0);
    check("R9 flag set", 32'(underflow), 1);
    push({7'd1, 9'h155}, "R9 recover", ia);
    check("R9 flag sticky", 32'(underflow), 1);
    @(negedge clk);
    tok_valid = 1'b0;
    repeat (6) @(negedge clk);

    // R10: reset clears the flag
    rst_n = 1'b0;
    #1 check("R10 flag cleared", 32'(underflow), 0);
    check("R10 rgb cleared", 32'(rgb_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule